// File: doc/BRIEF.md
# Hashed Key-Value Lookup Cache

This block holds a small set of popular key-value pairs on chip, so that a lookup for a hot key can be answered without touching external memory. Host software decides which keys live here and fills the block through a command port. The commands install a key into a slot of its choice, write value words into that slot's region of on-chip RAM, and invalidate a slot whose contents have gone stale. Lookup traffic only reads and never inserts or evicts anything.

A lookup presents a key of 1 to `KEY_BYTES` bytes. Two fixed, different hash functions turn the key into two candidate slot numbers. The primary candidate is probed first. The secondary candidate is probed only when the primary does not hold the key. A slot matches only when it is valid, its stored key length equals the lookup length, and every key byte inside that length is equal. A matching hash alone never counts as a hit. On a hit the slot's value is streamed out one word per beat over a valid/ready channel, with a last flag on the final word. On a miss a single beat comes out with the hit flag clear. Each slot's value region is 1 KiB with the default parameters (128 words of 64 bits).

Top module: `hkv_cache`

## Requirements
- R1: Key byte i sits at bits [8i+7:8i] of a key. The primary slot is the XOR of key bytes 0..klen-1 with klen, folded to SLOT_BITS bits by XOR-ing bit b into index bit (b mod SLOT_BITS). The secondary slot is 7 + sum over i<klen of byte_i*(2i+1), folded the same way.
- R2: A slot hits only when it is valid, its stored length equals the lookup length and bytes 0..klen-1 are equal. Key bytes at positions klen and above are ignored, both on install and on lookup. Two keys whose hashes collide are still told apart.
- R3: The primary slot is probed first. The secondary slot is probed only when the primary slot does not match. rsp_second is 1 exactly on beats served from the secondary slot.
- R4: A hit returns vlast+1 beats with rsp_hit=1, carrying the words at offsets 0 through vlast in increasing order. rsp_last is 1 only on the final beat.
- R5: A miss returns exactly one beat with rsp_hit=0, rsp_second=0, rsp_last=1 and rsp_data=0.
- R6: After an invalidate command, the slot reports no hit until it is installed again. Another slot holding the same key can then serve the lookup.
- R7: The lookup path never writes slot state: a key that missed still misses when looked up again, and installed entries keep their data.
- R8: While rsp_valid=1 and rsp_ready=0, all response outputs hold. lk_ready is 1 only when no lookup is in progress, and a lookup is accepted on a cycle with lk_valid=1 and lk_ready=1.
- R9: After reset, lk_ready=1, rsp_valid=0, and every slot is invalid.
- R10: cmd_op encoding, acting when cmd_valid=1: 0 installs key, length and vlast into cmd_slot and marks it valid; 1 writes cmd_wdata to word cmd_widx of cmd_slot; 2 invalidates cmd_slot; 3 has no effect.
- R11: Installing into an occupied slot replaces its key, so the old key no longer hits there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, one command per cycle |
| cmd_op | input | 2 | Command code (R10) |
| cmd_slot | input | SLOT_BITS | Target slot |
| cmd_key | input | 8*KEY_BYTES | Key to install |
| cmd_klen | input | KLEN_W | Key length in bytes to install |
| cmd_vlast | input | VAL_BITS | Offset of the last value word to install |
| cmd_widx | input | VAL_BITS | Word offset for a value write |
| cmd_wdata | input | WORD_W | Value word to write |
| lk_valid | input | 1 | Lookup request |
| lk_ready | output | 1 | Lookup accepted when high with lk_valid |
| lk_key | input | 8*KEY_BYTES | Lookup key |
| lk_klen | input | KLEN_W | Lookup key length in bytes |
| rsp_valid | output | 1 | Response beat valid |
| rsp_ready | input | 1 | Response beat consumed |
| rsp_hit | output | 1 | Beat belongs to a hit |
| rsp_second | output | 1 | Hit served from the secondary slot |
| rsp_last | output | 1 | Final beat of the response |
| rsp_data | output | WORD_W | Value word, zero on a miss |

## Verification
The hardest case to reach from the ports is a lookup whose primary slot is valid but holds a different key, so the hit must come from the secondary slot. Hash collisions that must still miss are similarly hard to produce. The bench carries its own arithmetic model of both hash functions. It searches the key space for keys whose two indices differ, or for pairs whose indices coincide. It then plants decoy keys in the primary slot or installs the same key in both candidates before each lookup.

// File: rtl/hkv_pkg.sv
package hkv_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        OP_INSTALL = 2'd0,
        OP_WRITE   = 2'd1,
        OP_DROP    = 2'd2,
        OP_RSVD    = 2'd3
    } cmd_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRI,
        ST_SEC,
        ST_FETCH,
        ST_SEND,
        ST_MISS
    } lk_state_e;

    // Width of the weighted-sum accumulator of the secondary hash
    function automatic int acc_width(input int key_bytes);
        return BYTE_W + 2 * $clog2(key_bytes) + 2;
    endfunction

endpackage

// File: rtl/hkv_keymask.sv
module hkv_keymask
    import hkv_pkg::*;
#(
    parameter int KEY_BYTES = 8,
    parameter int KLEN_W    = 4
) (
    input  logic [KEY_BYTES*BYTE_W-1:0] key_in,
    input  logic [KLEN_W-1:0]           klen,
    output logic [KEY_BYTES*BYTE_W-1:0] key_out
);

    // Zero every byte lane at or beyond the key length
    for (genvar g = 0; g < KEY_BYTES; g++) begin : g_lane
        assign key_out[g*BYTE_W +: BYTE_W] =
            (KLEN_W'(g) < klen) ? key_in[g*BYTE_W +: BYTE_W] : '0;
    end

endmodule

// File: rtl/hkv_hash.sv
module hkv_hash
    import hkv_pkg::*;
#(
    parameter int KEY_BYTES = 8,
    parameter int KLEN_W    = 4,
    parameter int SLOT_BITS = 3
) (
    input  logic [KEY_BYTES*BYTE_W-1:0] key_m,
    input  logic [KLEN_W-1:0]           klen,
    output logic [SLOT_BITS-1:0]        idx_pri,
    output logic [SLOT_BITS-1:0]        idx_sec
);

    localparam int ACC_W = acc_width(KEY_BYTES);

    logic [BYTE_W-1:0] fold_x;
    logic [ACC_W-1:0]  wsum;

    // Masked lanes are zero, so summing all lanes equals summing klen lanes
    always_comb begin
        fold_x = BYTE_W'(klen);
        wsum   = ACC_W'(7);
        for (int i = 0; i < KEY_BYTES; i++) begin
            fold_x = fold_x ^ key_m[i*BYTE_W +: BYTE_W];
            wsum   = wsum + ACC_W'(key_m[i*BYTE_W +: BYTE_W]) * ACC_W'(2*i + 1);
        end
        idx_pri = '0;
        idx_sec = '0;
        for (int b = 0; b < BYTE_W; b++)
            idx_pri[b % SLOT_BITS] = idx_pri[b % SLOT_BITS] ^ fold_x[b];
        for (int b = 0; b < ACC_W; b++)
            idx_sec[b % SLOT_BITS] = idx_sec[b % SLOT_BITS] ^ wsum[b];
    end

endmodule

// File: rtl/hkv_tags.sv
module hkv_tags
    import hkv_pkg::*;
#(
    parameter int KEY_BYTES = 8,
    parameter int KLEN_W    = 4,
    parameter int SLOT_BITS = 3,
    parameter int VAL_BITS  = 7
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        ins_en,
    input  logic                        drop_en,
    input  logic [SLOT_BITS-1:0]        wr_slot,
    input  logic [KEY_BYTES*BYTE_W-1:0] wr_key,
    input  logic [KLEN_W-1:0]           wr_klen,
    input  logic [VAL_BITS-1:0]         wr_vlast,
    input  logic [SLOT_BITS-1:0]        probe_slot,
    input  logic [KEY_BYTES*BYTE_W-1:0] probe_key_m,
    input  logic [KLEN_W-1:0]           probe_klen,
    output logic                        probe_hit,
    output logic [VAL_BITS-1:0]         probe_vlast
);

    localparam int SLOTS = 1 << SLOT_BITS;
    localparam int KEY_W = KEY_BYTES * BYTE_W;

    typedef struct packed {
        logic                valid;
        logic [KLEN_W-1:0]   klen;
        logic [KEY_W-1:0]    key;
        logic [VAL_BITS-1:0] vlast;
    } entry_t;

    entry_t           ent [SLOTS];
    logic [KEY_W-1:0] wr_key_m;

    hkv_keymask #(.KEY_BYTES(KEY_BYTES), .KLEN_W(KLEN_W)) u_wrmask (
        .key_in (wr_key),
        .klen   (wr_klen),
        .key_out(wr_key_m)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SLOTS; s++) ent[s] <= '0;
        end else if (ins_en) begin
            ent[wr_slot] <= '{valid: 1'b1, klen: wr_klen, key: wr_key_m, vlast: wr_vlast};
        end else if (drop_en) begin
            ent[wr_slot].valid <= 1'b0;
        end
    end

    always_comb begin
        probe_hit   = ent[probe_slot].valid
                   && (ent[probe_slot].klen == probe_klen)
                   && (ent[probe_slot].key == probe_key_m);
        probe_vlast = ent[probe_slot].vlast;
    end

endmodule

// File: rtl/hkv_vram.sv
module hkv_vram #(
    parameter int WORD_W = 64,
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WORD_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Registered read port: output holds until the next read strobe
    always_ff @(posedge clk) begin
        if (rst)     rdata <= '0;
        else if (re) rdata <= mem[raddr];
    end

endmodule

// File: rtl/hkv_cache.sv
module hkv_cache
    import hkv_pkg::*;
#(
    parameter int  KEY_BYTES = 8,
    parameter int  SLOT_BITS = 3,
    parameter int  VAL_BITS  = 7,
    parameter int  WORD_W    = 64,
    localparam int KEY_W     = KEY_BYTES * BYTE_W,
    localparam int KLEN_W    = $clog2(KEY_BYTES + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cmd_valid,
    input  logic [1:0]           cmd_op,
    input  logic [SLOT_BITS-1:0] cmd_slot,
    input  logic [KEY_W-1:0]     cmd_key,
    input  logic [KLEN_W-1:0]    cmd_klen,
    input  logic [VAL_BITS-1:0]  cmd_vlast,
    input  logic [VAL_BITS-1:0]  cmd_widx,
    input  logic [WORD_W-1:0]    cmd_wdata,
    input  logic                 lk_valid,
    output logic                 lk_ready,
    input  logic [KEY_W-1:0]     lk_key,
    input  logic [KLEN_W-1:0]    lk_klen,
    output logic                 rsp_valid,
    input  logic                 rsp_ready,
    output logic                 rsp_hit,
    output logic                 rsp_second,
    output logic                 rsp_last,
    output logic [WORD_W-1:0]    rsp_data
);

    localparam int ADDR_W = SLOT_BITS + VAL_BITS;

    cmd_op_e   op_k;
    lk_state_e st;

    logic [KEY_W-1:0]     lk_key_m;
    logic [SLOT_BITS-1:0] h_pri, h_sec;
    logic [KEY_W-1:0]     key_q;
    logic [KLEN_W-1:0]    klen_q;
    logic [SLOT_BITS-1:0] idx_pri_q, idx_sec_q, sel_q, probe_slot;
    logic                 second_q;
    logic [VAL_BITS-1:0]  widx_q, vlast_q, probe_vlast;
    logic                 probe_hit;
    logic [WORD_W-1:0]    rd_data;

    assign op_k = cmd_op_e'(cmd_op);

    hkv_keymask #(.KEY_BYTES(KEY_BYTES), .KLEN_W(KLEN_W)) u_lkmask (
        .key_in (lk_key),
        .klen   (lk_klen),
        .key_out(lk_key_m)
    );

    hkv_hash #(.KEY_BYTES(KEY_BYTES), .KLEN_W(KLEN_W), .SLOT_BITS(SLOT_BITS)) u_hash (
        .key_m  (lk_key_m),
        .klen   (lk_klen),
        .idx_pri(h_pri),
        .idx_sec(h_sec)
    );

    assign probe_slot = (st == ST_SEC) ? idx_sec_q : idx_pri_q;

    hkv_tags #(
        .KEY_BYTES(KEY_BYTES), .KLEN_W(KLEN_W),
        .SLOT_BITS(SLOT_BITS), .VAL_BITS(VAL_BITS)
    ) u_tags (
        .clk        (clk),
        .rst        (rst),
        .ins_en     (cmd_valid && op_k == OP_INSTALL),
        .drop_en    (cmd_valid && op_k == OP_DROP),
        .wr_slot    (cmd_slot),
        .wr_key     (cmd_key),
        .wr_klen    (cmd_klen),
        .wr_vlast   (cmd_vlast),
        .probe_slot (probe_slot),
        .probe_key_m(key_q),
        .probe_klen (klen_q),
        .probe_hit  (probe_hit),
        .probe_vlast(probe_vlast)
    );

    hkv_vram #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_vram (
        .clk  (clk),
        .rst  (rst),
        .we   (cmd_valid && op_k == OP_WRITE),
        .waddr({cmd_slot, cmd_widx}),
        .wdata(cmd_wdata),
        .re   (st == ST_FETCH),
        .raddr({sel_q, widx_q}),
        .rdata(rd_data)
    );

    assign lk_ready   = (st == ST_IDLE);
    assign rsp_valid  = (st == ST_SEND) || (st == ST_MISS);
    assign rsp_hit    = (st == ST_SEND);
    assign rsp_second = (st == ST_SEND) && second_q;
    assign rsp_last   = (st == ST_MISS) || ((st == ST_SEND) && (widx_q == vlast_q));
    assign rsp_data   = (st == ST_SEND) ? rd_data : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            key_q     <= '0;
            klen_q    <= '0;
            idx_pri_q <= '0;
            idx_sec_q <= '0;
            sel_q     <= '0;
            second_q  <= 1'b0;
            widx_q    <= '0;
            vlast_q   <= '0;
        end else begin
            unique case (st)
                ST_IDLE: if (lk_valid) begin
                    key_q     <= lk_key_m;
                    klen_q    <= lk_klen;
                    idx_pri_q <= h_pri;
                    idx_sec_q <= h_sec;
                    st        <= ST_PRI;
                end
                ST_PRI: if (probe_hit) begin
                    sel_q    <= idx_pri_q;
                    second_q <= 1'b0;
                    vlast_q  <= probe_vlast;
                    widx_q   <= '0;
                    st       <= ST_FETCH;
                end else begin
                    st <= ST_SEC;
                end
                ST_SEC: if (probe_hit) begin
                    sel_q    <= idx_sec_q;
                    second_q <= 1'b1;
                    vlast_q  <= probe_vlast;
                    widx_q   <= '0;
                    st       <= ST_FETCH;
                end else begin
                    st <= ST_MISS;
                end
                ST_FETCH: st <= ST_SEND;
                ST_SEND: if (rsp_ready) begin
                    if (widx_q == vlast_q) begin
                        st <= ST_IDLE;
                    end else begin
                        widx_q <= widx_q + 1'b1;
                        st     <= ST_FETCH;
                    end
                end
                ST_MISS: if (rsp_ready) st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/hkv_cache_chk.sv
module hkv_cache_chk #(
    parameter int WORD_W = 64
) (
    input logic              clk,
    input logic              rst,
    input logic              lk_valid,
    input logic              lk_ready,
    input logic              rsp_valid,
    input logic              rsp_ready,
    input logic              rsp_hit,
    input logic              rsp_second,
    input logic              rsp_last,
    input logic [WORD_W-1:0] rsp_data
);

    // R8
    rsp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) && $stable(rsp_hit)
                                    && $stable(rsp_last) && $stable(rsp_second));

    // R8
    busy_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !lk_ready);

    // R8
    accept_chk: assert property (@(posedge clk) disable iff (rst)
        lk_valid && lk_ready |=> !lk_ready && !rsp_valid);

    // R5
    miss_beat_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && !rsp_hit |-> rsp_last && !rsp_second && (rsp_data == '0));

    // R3
    second_hit_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && rsp_second |-> rsp_hit);

    // R4
    end_idle_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && rsp_ready && rsp_last |=> !rsp_valid && lk_ready);

    // R9
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> lk_ready && !rsp_valid);

endmodule

bind hkv_cache hkv_cache_chk #(.WORD_W(WORD_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .lk_valid  (lk_valid),
    .lk_ready  (lk_ready),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_hit   (rsp_hit),
    .rsp_second(rsp_second),
    .rsp_last  (rsp_last),
    .rsp_data  (rsp_data)
);

// File: tb/hkv_cache_test.sv
module hkv_cache_test;

    localparam int CLK_PERIOD = 10;
    localparam int KB = 4;
    localparam int SB = 3;
    localparam int VB = 2;
    localparam int WW = 32;
    localparam int NSLOT = 1 << SB;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = '0;
    logic [2:0]  cmd_slot = '0;
    logic [31:0] cmd_key = '0;
    logic [2:0]  cmd_klen = '0;
    logic [1:0]  cmd_vlast = '0;
    logic [1:0]  cmd_widx = '0;
    logic [31:0] cmd_wdata = '0;
    logic        lk_valid = 1'b0;
    logic        lk_ready;
    logic [31:0] lk_key = '0;
    logic [2:0]  lk_klen = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic        rsp_hit, rsp_second, rsp_last;
    logic [31:0] rsp_data;

    int checks = 0;
    int fails = 0;
    int stall_ctr = 0;
    bit finished = 0;
    logic [31:0] seed = 32'h1234_5678;

    // Reference model of slot contents
    bit          m_valid [NSLOT];
    logic [31:0] m_key   [NSLOT];
    int          m_klen  [NSLOT];
    int          m_vlast [NSLOT];
    logic [31:0] m_word  [NSLOT][4];

    always #(CLK_PERIOD/2) clk = ~clk;

    hkv_cache #(.KEY_BYTES(KB), .SLOT_BITS(SB), .VAL_BITS(VB), .WORD_W(WW)) uut (
        .clk(clk), .rst(rst),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_slot(cmd_slot), .cmd_key(cmd_key),
        .cmd_klen(cmd_klen), .cmd_vlast(cmd_vlast), .cmd_widx(cmd_widx), .cmd_wdata(cmd_wdata),
        .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_key(lk_key), .lk_klen(lk_klen),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_hit(rsp_hit),
        .rsp_second(rsp_second), .rsp_last(rsp_last), .rsp_data(rsp_data)
    );

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    task automatic check(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    function automatic logic [31:0] next_rand();
        seed = seed * 32'd1103515245 + 32'd12345;
        return seed;
    endfunction

    function automatic logic [31:0] masked(input logic [31:0] key, input int klen);
        logic [31:0] r = '0;
        for (int i = 0; i < klen; i++) r[8*i +: 8] = key[8*i +: 8];
        return r;
    endfunction

    // R1 primary: xor of bytes and length, bit b folded into index bit b mod SB
    function automatic int bh1(input logic [31:0] key, input int klen);
        int x = klen;
        int idx = 0;
        for (int i = 0; i < klen; i++) x = x ^ int'(key[8*i +: 8]);
        for (int b = 0; b < 32; b++) if (((x >> b) & 1) == 1) idx = idx ^ (1 << (b % SB));
        return idx;
    endfunction

    // R1 secondary: 7 + weighted byte sum, folded the same way
    function automatic int bh2(input logic [31:0] key, input int klen);
        int s = 7;
        int idx = 0;
        for (int i = 0; i < klen; i++) s = s + int'(key[8*i +: 8]) * (2*i + 1);
        for (int b = 0; b < 32; b++) if (((s >> b) & 1) == 1) idx = idx ^ (1 << (b % SB));
        return idx;
    endfunction

    function automatic bit mmatch(input int s, input logic [31:0] key, input int klen);
        return m_valid[s] && (m_klen[s] == klen) && (m_key[s] == masked(key, klen));
    endfunction

    function automatic logic [31:0] wv(input int s, input int w, input int gen);
        return 32'h5A00_0000 ^ 32'(gen << 12) ^ 32'(s << 8) ^ 32'(w);
    endfunction

    task automatic do_cmd(input logic [1:0] op, input int slot, input logic [31:0] key,
                          input int klen, input int vlast, input int widx, input logic [31:0] wd);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_slot  = 3'(slot);
        cmd_key   = key;
        cmd_klen  = 3'(klen);
        cmd_vlast = 2'(vlast);
        cmd_widx  = 2'(widx);
        cmd_wdata = wd;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic fill(input int slot, input logic [31:0] key, input int klen, input int vlast, input int gen);
        do_cmd(2'd0, slot, key, klen, vlast, 0, 32'h0);
        m_valid[slot] = 1'b1;
        m_key[slot]   = masked(key, klen);
        m_klen[slot]  = klen;
        m_vlast[slot] = vlast;
        for (int w = 0; w <= vlast; w++) begin
            do_cmd(2'd1, slot, 32'h0, 0, 0, w, wv(slot, w, gen));
            m_word[slot][w] = wv(slot, w, gen);
        end
    endtask

    task automatic drop(input int slot);
        do_cmd(2'd2, slot, 32'h0, 0, 0, 0, 32'h0);
        m_valid[slot] = 1'b0;
    endtask

    task automatic lookup(input logic [31:0] key, input int klen, input string tag);
        int p, q, slot, vl, w, t, nexp;
        bit eh, es, done, held;
        logic [34:0] cur, held_v, exv;
        logic ex_last;
        logic [31:0] ex_data;
        p = bh1(key, klen);
        q = bh2(key, klen);
        eh = 0; es = 0; slot = 0; vl = 0;
        if (mmatch(p, key, klen)) begin
            eh = 1; slot = p;
        end else if (mmatch(q, key, klen)) begin
            eh = 1; es = 1; slot = q;
        end
        if (eh) vl = m_vlast[slot];
        lk_key = key;
        lk_klen = 3'(klen);
        lk_valid = 1'b1;
        t = 0;
        while (!lk_ready && t < 100) begin
            @(negedge clk);
            t++;
        end
        @(negedge clk);
        lk_valid = 1'b0;
        w = 0; done = 0; held = 0; t = 0;
        while (!done && t < 400) begin
            rsp_ready = (stall_ctr % 3) != 1;
            stall_ctr++;
            if (rsp_valid) begin
                cur = {rsp_hit, rsp_second, rsp_last, rsp_data};
                if (held) check(cur == held_v, "R8 hold while stalled", 64'(cur), 64'(held_v));
                check(!lk_ready, "R8 lookup port busy", 64'(lk_ready), 64'd0);
                if (rsp_ready) begin
                    ex_last = eh ? (w == vl) : 1'b1;
                    ex_data = eh ? m_word[slot][w & 3] : 32'h0;
                    exv = {eh, es, ex_last, ex_data};
                    check(cur == exv, tag, 64'(cur), 64'(exv));
                    w++;
                    if (rsp_last) done = 1;
                    held = 0;
                end else begin
                    held = 1;
                    held_v = cur;
                end
            end
            @(negedge clk);
            t++;
        end
        rsp_ready = 1'b0;
        nexp = eh ? vl + 1 : 1;
        if (!done) check(1'b0, {tag, " response timeout"}, 64'(w), 64'(nexp));
        else check(w == nexp, {tag, " beat count"}, 64'(w), 64'(nexp));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected completion");
            report();
            $finish;
        end
    end

    initial begin
        logic [31:0] k, c, kn, big;
        int s, found;
        for (int i = 0; i < NSLOT; i++) m_valid[i] = 1'b0;

        // R9 reset state
        repeat (3) @(negedge clk);
        check(lk_ready == 1'b1, "R9 lk_ready after reset", 64'(lk_ready), 64'd1);
        check(rsp_valid == 1'b0, "R9 rsp_valid after reset", 64'(rsp_valid), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 8; i++) lookup(32'(i * 37 + 5), 1 + (i % 4), "R9 R5 empty after reset");

        // R1 R4: every one-byte key installed at its primary slot
        for (int i = 0; i < 256; i++) begin
            fill(bh1(32'(i), 1), 32'(i), 1, i % 4, i);
            lookup(32'(i), 1, "R1 R4 primary hit stream");
            if (i % 16 == 0) lookup(32'(i) | 32'h0000_AB00, 2, "R2 R5 longer key");
        end

        // R3 R1: secondary slot hits behind an empty or decoy primary
        for (int n = 0; n < 40; n++) begin
            k = next_rand();
            if (bh1(k, 4) != bh2(k, 4)) begin
                if (n % 2 == 0) drop(bh1(k, 4));
                else fill(bh1(k, 4), k ^ 32'h0000_0100, 4, 0, 900 + n);
                fill(bh2(k, 4), k, 4, n % 4, 500 + n);
                lookup(k, 4, "R3 R1 secondary hit");
            end
        end

        // R3 priority then R6 invalidation
        found = 0;
        k = 32'h0;
        while (!found) begin
            k = next_rand();
            if (bh1(k, 4) != bh2(k, 4)) found = 1;
        end
        fill(bh1(k, 4), k, 4, 3, 1000);
        fill(bh2(k, 4), k, 4, 1, 2000);
        lookup(k, 4, "R3 primary probed first");
        drop(bh1(k, 4));
        lookup(k, 4, "R6 invalidated primary");
        drop(bh2(k, 4));
        lookup(k, 4, "R6 R5 invalidated both");

        // R2 masking and exact compare
        big = 32'h1122_3344;
        fill(bh1(big, 2), big, 2, 2, 3000);
        lookup(32'hFFEE_3344, 2, "R2 bytes beyond length ignored");
        lookup(big, 3, "R2 length must match");
        lookup(32'h1122_3345, 2, "R2 byte mismatch");

        // R2 hash collision: same two indices, different key
        k = 32'h21;
        c = 32'h0;
        found = 0;
        for (int j = 0; j < 256; j++) begin
            if (!found && j != 32'h21 && bh1(32'(j), 1) == bh1(k, 1) && bh2(32'(j), 1) == bh2(k, 1)) begin
                c = 32'(j);
                found = 1;
            end
        end
        if (found) begin
            drop(bh2(k, 1));
            fill(bh1(k, 1), k, 1, 0, 3500);
            lookup(c, 1, "R2 colliding key misses");
            lookup(k, 1, "R2 installed key hits");
        end

        // R10 reserved op has no effect
        do_cmd(2'd3, bh1(big, 2), 32'hDEAD_BEEF, 4, 3, 0, 32'hCAFE_F00D);
        lookup(big, 2, "R10 reserved op no effect");
        lookup(32'hDEAD_BEEF, 4, "R10 reserved op did not install");

        // R11 overwrite of an occupied slot
        s = bh1(big, 2);
        found = 0;
        kn = 32'h0;
        while (!found) begin
            kn = next_rand();
            if (bh1(kn, 4) == s && masked(kn, 2) != masked(big, 2)) found = 1;
        end
        fill(s, kn, 4, 1, 4000);
        lookup(big, 2, "R11 replaced key gone");
        lookup(kn, 4, "R11 new key hits");

        // R7 a miss does not insert
        lookup(32'h0BAD_0BAD, 4, "R5 R7 first miss");
        lookup(32'h0BAD_0BAD, 4, "R7 repeated miss");
        lookup(kn, 4, "R7 entries untouched");

        finished = 1;
        report();
        $finish;
    end

endmodule